// File: doc/BRIEF.md
# Bit-Serial AND-Rotate-XOR Feistel Cipher Core

This block encrypts one 64-bit block under a 128-bit key with a two-branch Feistel cipher. Each round computes a new left half as `y ^ f(x) ^ k`, where `f(x) = (ROL1(x) & ROL8(x)) ^ ROL2(x)`; the old left half becomes the new right half. There are 44 rounds. The whole datapath works on one bit per clock. The left half, the right half and the four key words each sit in a shift register that moves one place right per clock. A single freshly computed bit enters at the left end. Word rotations are never formed in parallel. They become fixed tap points in the registers, and a comparison against the bit counter chooses the tap for the bits that wrap around the word.

The round key is produced on the fly in the same one-bit-per-clock fashion. The four key words form one 128-bit chain. The current round key leaves at bit 0. The next schedule word is built from taps on the chain and shifted in at bit 127. A controller with three states (`ST_IDLE`, `ST_RUN`, `ST_DONE`) sequences the work using a 5-bit bit counter and a 6-bit round counter.

The state transitions are:
- `ST_IDLE`→`ST_RUN` on `start`.
- `ST_RUN`→`ST_DONE` after bit 31 of round 43.
- `ST_DONE`→`ST_RUN` on a new `start`.

A host presents plaintext and key in parallel, pulses `start`, and reads `ct_o` while `done_o` is high.

Top module: `fsc_bitserial_cipher`

## Requirements
- R1: While reset is applied and in the first cycle after reset, `done_o` is 0 and `ct_o` is all zeros.
- R2: A `start` seen in `ST_IDLE` or `ST_DONE` loads the key and loads the plaintext. One clock later `ct_o` equals `pt_i`, with the left half in `pt_i[63:32]` and the right half in `pt_i[31:0]`.
- R3: On every clock in `ST_RUN`, `ct_o` moves right by one bit, so `ct_o[62:0]` equals the previous `ct_o[63:1]`. Exactly one new bit enters at `ct_o[63]`.
- R4: The round computes `x' = y ^ ((ROL1(x) & ROL8(x)) ^ ROL2(x)) ^ k_i` and `y' = x`, with left half `x` and right half `y`. After 44 rounds `ct_o` holds `{x, y}`.
- R5: The round keys are built as follows:
  - Key words are `k_0..k_3 = key_i[31:0], [63:32], [95:64], [127:96]`.
  - For each later word, let `t = ROR3(k_{i+3}) ^ k_{i+1}`. Then `k_{i+4} = ~k_i ^ t ^ ROR1(t) ^ 3 ^ z_i`.
  - `z_i` is bit `i` (LSB = round 0) of the constant `62'h3C2CE51207A635DB`.
- R6: `done_o` rises exactly 1408 (44 × 32) clocks after the clock edge that loads the operands.
- R7: In `ST_DONE` without `start`, `done_o` stays 1 and `ct_o` stays unchanged.
- R8: A `start` pulse during `ST_RUN` is ignored. The running result and its timing are unaffected.
- R9: Plaintext `656b696c20646e75` under key `1b1a1918131211100b0a090803020100` yields `44c8fc20b9dfa07a`.
- R10: A `start` in `ST_DONE` begins a new operation at once, and `done_o` is 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load operands and begin, honoured outside `ST_RUN` |
| pt_i | input | 64 | Plaintext, left half in the upper 32 bits |
| key_i | input | 128 | Key, word 0 in the lower 32 bits |
| ct_o | output | 64 | Block state; ciphertext when `done_o` is high |
| done_o | output | 1 | High in `ST_DONE` |

## Verification
The assertions take for granted that `pt_i` and `key_i` matter only on a cycle where `start` is accepted. They also assume `start` may arrive in any state, including in the middle of a run, where it must have no effect. The stimulus changes the operands only alongside a `start` pulse. It raises `start` once mid-run on purpose, with the operands inverted. It also raises `start` on the very cycle a result is presented, so that the back-to-back path and the ignore path are both exercised within those assumptions.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int unsigned FSC_WORD   = 32;
    localparam int unsigned FSC_ROUNDS = 44;
    localparam int unsigned FSC_KWORDS = 4;

    // round-function rotation amounts (left)
    localparam int unsigned ROT_AND_A = 1;
    localparam int unsigned ROT_AND_B = 8;
    localparam int unsigned ROT_XOR   = 2;

    // key-schedule rotation amounts (right)
    localparam int unsigned KROT_BIG   = 3;
    localparam int unsigned KROT_SMALL = 1;

    // per-round schedule constant, bit i used in round i
    localparam logic [61:0] Z_SEQ = 62'h3C2CE51207A635DB;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } fsc_state_e;

endpackage

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
    import fsc_pkg::*;
#(
    parameter int unsigned W  = FSC_WORD,
    parameter int unsigned R  = FSC_ROUNDS,
    localparam int unsigned BW = $clog2(W),
    localparam int unsigned RW = $clog2(R)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          load,
    output logic          shift_en,
    output logic [BW-1:0] bit_idx,
    output logic [RW-1:0] rnd_idx,
    output logic          done
);

    fsc_state_e state_q, state_d;
    logic       last_bit, last_rnd;

    assign last_bit = (bit_idx == BW'(W - 1));
    assign last_rnd = (rnd_idx == RW'(R - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (last_bit && last_rnd) state_d = ST_DONE;
            ST_DONE: if (start) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bit and round counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            rnd_idx <= '0;
        end else if (load) begin
            bit_idx <= '0;
            rnd_idx <= '0;
        end else if (shift_en) begin
            if (last_bit) begin
                bit_idx <= '0;
                rnd_idx <= last_rnd ? '0 : rnd_idx + 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        load     = 1'b0;
        shift_en = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN:  shift_en = 1'b1;
            ST_DONE: begin
                load = start;
                done = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fsc_dpath.sv
module fsc_dpath
    import fsc_pkg::*;
#(
    parameter int unsigned W  = FSC_WORD,
    localparam int unsigned BW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift_en,
    input  logic [BW-1:0] bit_idx,
    input  logic [W-1:0]  x_ld,
    input  logic [W-1:0]  y_ld,
    input  logic          rk_bit,
    output logic [W-1:0]  x_q,
    output logic [W-1:0]  y_q
);

    // Old left-half bit (j - m) sits at position W-m: still in x_q while
    // j < m (wrapped part), already moved into y_q once j >= m.
    logic tap_a, tap_b, tap_c, new_bit;

    assign tap_a = (bit_idx < BW'(ROT_AND_A)) ? x_q[W-ROT_AND_A] : y_q[W-ROT_AND_A];
    assign tap_b = (bit_idx < BW'(ROT_AND_B)) ? x_q[W-ROT_AND_B] : y_q[W-ROT_AND_B];
    assign tap_c = (bit_idx < BW'(ROT_XOR))   ? x_q[W-ROT_XOR]   : y_q[W-ROT_XOR];

    assign new_bit = y_q[0] ^ (tap_a & tap_b) ^ tap_c ^ rk_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else if (load) begin
            x_q <= x_ld;
            y_q <= y_ld;
        end else if (shift_en) begin
            x_q <= {new_bit, x_q[W-1:1]};
            y_q <= {x_q[0],  y_q[W-1:1]};
        end
    end

endmodule

// File: rtl/fsc_kpath.sv
module fsc_kpath
    import fsc_pkg::*;
#(
    parameter int unsigned W  = FSC_WORD,
    localparam int unsigned BW = $clog2(W),
    localparam int unsigned KB = FSC_KWORDS * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift_en,
    input  logic [BW-1:0] bit_idx,
    input  logic          z_bit,
    input  logic [KB-1:0] key_ld,
    output logic          rk_bit
);

    localparam int unsigned KR2 = KROT_BIG + KROT_SMALL;

    logic [KB-1:0] k_q;
    logic w1_lo, w1_hi, w3_lo, w3_hi, tmp_lo, tmp_hi, cst, nk_bit;

    // word1 bit j and j+1 (wraps to old bit 0 at position 1 when j = W-1)
    assign w1_lo = k_q[W];
    assign w1_hi = (bit_idx == BW'(W - 1)) ? k_q[1] : k_q[W + 1];
    // word3 bits j+3 and j+4, wrapping back into the older copy
    assign w3_lo = (bit_idx < BW'(W - KROT_BIG)) ? k_q[3*W + KROT_BIG] : k_q[2*W + KROT_BIG];
    assign w3_hi = (bit_idx < BW'(W - KR2))      ? k_q[3*W + KR2]      : k_q[2*W + KR2];

    assign tmp_lo = w3_lo ^ w1_lo;
    assign tmp_hi = w3_hi ^ w1_hi;
    // ~k ^ 3 inverts all but the two low bits; z enters at bit 0
    assign cst    = (bit_idx >= BW'(2)) ^ ((bit_idx == '0) & z_bit);
    assign nk_bit = k_q[0] ^ tmp_lo ^ tmp_hi ^ cst;

    assign rk_bit = k_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        k_q <= '0;
        else if (load)     k_q <= key_ld;
        else if (shift_en) k_q <= {nk_bit, k_q[KB-1:1]};
    end

endmodule

// File: rtl/fsc_bitserial_cipher.sv
module fsc_bitserial_cipher
    import fsc_pkg::*;
#(
    parameter int unsigned W = FSC_WORD,
    parameter int unsigned R = FSC_ROUNDS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [2*W-1:0]            pt_i,
    input  logic [FSC_KWORDS*W-1:0]   key_i,
    output logic [2*W-1:0]            ct_o,
    output logic                      done_o
);

    localparam int unsigned BW = $clog2(W);
    localparam int unsigned RW = $clog2(R);

    logic          load, shift_en, rk_bit, z_bit;
    logic [BW-1:0] bit_idx;
    logic [RW-1:0] rnd_idx;
    logic [W-1:0]  x_q, y_q;

    assign z_bit = Z_SEQ[rnd_idx];

    fsc_ctrl #(.W(W), .R(R)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load     (load),
        .shift_en (shift_en),
        .bit_idx  (bit_idx),
        .rnd_idx  (rnd_idx),
        .done     (done_o)
    );

    fsc_dpath #(.W(W)) u_dpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift_en (shift_en),
        .bit_idx  (bit_idx),
        .x_ld     (pt_i[2*W-1:W]),
        .y_ld     (pt_i[W-1:0]),
        .rk_bit   (rk_bit),
        .x_q      (x_q),
        .y_q      (y_q)
    );

    fsc_kpath #(.W(W)) u_kpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift_en (shift_en),
        .bit_idx  (bit_idx),
        .z_bit    (z_bit),
        .key_ld   (key_i),
        .rk_bit   (rk_bit)
    );

    assign ct_o = {x_q, y_q};

endmodule

// File: rtl/fsc_chk.sv
module fsc_chk #(
    parameter int unsigned W = 32,
    parameter int unsigned R = 44
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         load,
    input logic         running,
    input logic [2*W-1:0] pt_i,
    input logic [2*W-1:0] ct_o,
    input logic         done_o
);

    localparam int unsigned LAT = W * R;
    localparam int unsigned CW  = $clog2(LAT + 1) + 1;

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_cnt <= '0;
        else if (load)    run_cnt <= '0;
        else if (running) run_cnt <= run_cnt + 1'b1;
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ct_o == $past(pt_i));

    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> ct_o[2*W-2:0] == $past(ct_o[2*W-1:1]));

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> run_cnt == CW'(LAT));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start) |=> (done_o && $stable(ct_o)));

    p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start) |=> run_cnt == $past(run_cnt) + 1'b1);

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start) |=> !done_o);

endmodule

bind fsc_bitserial_cipher fsc_chk #(.W(W), .R(R)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .load    (load),
    .running (shift_en),
    .pt_i    (pt_i),
    .ct_o    (ct_o),
    .done_o  (done_o)
);

// File: tb/sim_fsc_bitserial_cipher.sv
`timescale 1ns/1ps
module sim_fsc_bitserial_cipher;

    localparam int LAT = 44 * 32;
    localparam logic [61:0] ZC = 62'h3C2CE51207A635DB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [63:0]   pt_i = '0;
    logic [127:0]  key_i = '0;
    logic [63:0]   ct_o;
    logic          done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [63:0] exp_q[$];
    logic [63:0] mon_exp;
    logic        done_d = 1'b0;

    always #2.5 clk = ~clk;

    fsc_bitserial_cipher u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pt_i(pt_i), .key_i(key_i), .ct_o(ct_o), .done_o(done_o)
    );

    function automatic logic [31:0] rol(input logic [31:0] v, input int s);
        return (v << s) | (v >> (32 - s));
    endfunction

    function automatic logic [31:0] ror(input logic [31:0] v, input int s);
        return (v >> s) | (v << (32 - s));
    endfunction

    function automatic logic [63:0] ref_enc(input logic [63:0] p, input logic [127:0] k);
        logic [31:0] rk [44];
        logic [31:0] x, y, t;
        for (int i = 0; i < 4; i++) rk[i] = k[32*i +: 32];
        for (int i = 0; i < 40; i++) begin
            t = ror(rk[i+3], 3) ^ rk[i+1];
            t = t ^ ror(t, 1);
            rk[i+4] = ~rk[i] ^ t ^ {31'd0, ZC[i]} ^ 32'd3;
        end
        x = p[63:32];
        y = p[31:0];
        for (int i = 0; i < 44; i++) begin
            t = x;
            x = y ^ ((rol(x, 1) & rol(x, 8)) ^ rol(x, 2)) ^ rk[i];
            y = t;
        end
        return {x, y};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // monitor: pops the scoreboard whenever a result is presented
    always @(negedge clk) begin
        if (!rst_n) begin
            done_d = 1'b0;
        end else begin
            if (done_o && !done_d) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected result", ct_o, '0);
                end else begin
                    mon_exp = exp_q.pop_front();
                    chk(ct_o == mon_exp, "R4/R5 ciphertext", ct_o, mon_exp);
                end
            end
            done_d = done_o;
        end
    end

    // driver: called at a negedge
    task automatic run_op(input logic [63:0] p, input logic [127:0] k,
                          input int inject, input int hold);
        logic [63:0] e, prev;
        int cnt;
        e = ref_enc(p, k);
        exp_q.push_back(e);
        pt_i = p; key_i = k; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(ct_o == p, "R2 operands loaded", ct_o, p);
        chk(done_o == 1'b0, "R10 done drops after start", {63'd0, done_o}, 64'd0);
        prev = ct_o;
        @(negedge clk);
        cnt = 1;
        chk(ct_o[62:0] == prev[63:1], "R3 one-bit shift", {1'b0, ct_o[62:0]}, {1'b0, prev[63:1]});
        while (!done_o && cnt < 3000) begin
            start = (cnt == inject);
            if (start) begin
                pt_i = ~p;
                key_i = ~k;
            end
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        chk(cnt == LAT, "R6 latency", 64'(cnt), 64'(LAT));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(done_o && ct_o == e, "R7 result held", ct_o, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R6: actual=hung expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done_o == 1'b0 && ct_o == '0, "R1 in reset", ct_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o == 1'b0 && ct_o == '0, "R1 after reset", ct_o, '0);

        // R9 known-answer vector
        run_op(64'h656b696c20646e75, 128'h1b1a1918131211100b0a090803020100, -1, 6);
        chk(ct_o == 64'h44c8fc20b9dfa07a, "R9 known answer", ct_o, 64'h44c8fc20b9dfa07a);

        // R8 start mid-run ignored
        run_op(64'h0123456789abcdef, 128'hfedcba98765432100f1e2d3c4b5a6978, 500, 0);
        // R10 back-to-back restart straight from done
        run_op(64'h0, 128'h0, -1, 2);
        run_op(64'hffffffffffffffff, {128{1'b1}}, 7, 2);
        run_op(64'ha5a5a5a55a5a5a5a, 128'h8000000000000000000000000000_0001, -1, 0);
        run_op(64'h0000000180000000, 128'h00000001000000020000000400000008, -1, 3);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all results seen", 64'(exp_q.size()), 64'd0);
        summary();
    end

endmodule